// File: doc/BRIEF.md
# Three-Wire Serial Register Access Port

This block is the slave side of a three-wire serial link into a small register file. An external host raises an active-high select line, toggles a serial clock and moves bits over a single data line that both ends can drive. On chip that line is split into an input, an output and an output enable. Each transaction opens with a command byte. Its low seven bits name a register and its top bit chooses the direction. Any number of data bytes follow, and the register address steps forward after each one. Every byte travels least significant bit first.

The block runs in the system clock domain. The three serial inputs are oversampled through a synchroniser, and edges of the serial clock are found from the synchronised copy. Toward the register file it presents an address, a one-cycle write strobe with data, a one-cycle read strobe and a combinational read-data input. The block enforces three rules of its own. Addresses above the last implemented register read back as zero and cannot be written. No write strobe is issued while the write-protect input is high. While a byte of the conversion-result register is being read, a hold signal stops the converter from updating that register.

Top module: `tw_serial_regif`

## Requirements
- R1: A rising select starts a new command phase. A low select ends any transfer, and the output enable `sdio_oe` falls in the same cycle that select is seen low.
- R2: The first byte after select rises is the command. Bits 6..0 give the start address. Bit 7 = 1 makes the transfer a write and bit 7 = 0 makes it a read. A read strobe and a write strobe never occur together.
- R3: Command bytes and data bytes, in both directions, move least significant bit first.
- R4: Incoming bits are taken at rising serial-clock edges and outgoing bits change at falling edges. In a read, `sdio_oe` stays low through the command byte. The first data bit (bit 0) appears at the falling edge that follows the eighth command bit.
- R5: In a burst the address advances by one after each data byte and wraps from 0Eh to 00h. Above 0Eh it counts up through 7Fh and wraps to 00h.
- R6: Addresses 0Fh to 7Fh return 00h on reads, whatever `reg_rdata` holds, and never produce a write strobe or a read strobe.
- R7: While `wp` is 1, no write strobe is issued for any address.
- R8: `adc_hold` is high only while a read transfer is addressing 0Eh. It drops once that byte is done or once select goes low.
- R9: A write strobe is issued only after all eight data bits of a byte have arrived, and it lasts one clock. A byte cut short by select falling is discarded.
- R10: After reset no strobe is active, `sdio_oe` and `adc_hold` are low and `reg_addr` is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Serial select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data line, input side |
| sdio_out | output | 1 | Serial data line, output side |
| sdio_oe | output | 1 | Drive enable for the serial data line |
| wp | input | 1 | Write protect; 1 blocks every write |
| reg_addr | output | 7 | Register address toward the register file |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd_en | output | 1 | One-cycle read strobe as a byte is loaded for output |
| reg_rdata | input | 8 | Read data from the register file (combinational on `reg_addr`) |
| adc_hold | output | 1 | Blocks updates of the conversion-result register during its read |

## Verification
The main path is driven from a vector table that mixes single writes and reads with asymmetric data patterns such as 37h and C4h. A bit-order or direction-bit mistake therefore reads back a visibly different value. Reserved reads use a register-file input that returns A5h, so a missing zero-forcing shows up at once. Bursts start at 0Dh and 0Eh to tell a correct wrap to 00h from a plain 7-bit count. Directed cases separate a completed byte from a truncated one, protected writes from unprotected ones, and a hold that is released by deselection from one that is not.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 8;
    localparam int CNT_W  = $clog2(DATA_W) + 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_CMD,
        PH_WR,
        PH_RD
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [CNT_W-1:0]    bcnt;
        logic [DATA_W-1:0]   rx;
        logic [DATA_W-1:0]   tx;
        logic [ADDR_W-1:0]   addr;
        logic                adv;
        logic                drive;
        logic                wr_en;
        logic                rd_en;
        logic [DATA_W-1:0]   wdata;
        logic                sclk_prev;
        logic                cs_prev;
    } eng_s;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/tw_engine.sv
module tw_engine
    import tw_pkg::*;
#(
    parameter int LAST_ADDR = 14,
    parameter int ADC_ADDR  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic              wp,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    output logic              sdo,
    output logic              drive,
    output logic              adc_hold
);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LAST_ADDR);
    localparam logic [ADDR_W-1:0] ADC_A  = ADDR_W'(ADC_ADDR);
    localparam logic [CNT_W-1:0]  BYTE_END = CNT_W'(DATA_W - 1);

    eng_s q, d;

    logic              rise, fall, reserved;
    logic [DATA_W-1:0] shifted;

    always_comb begin
        d         = q;
        d.wr_en   = 1'b0;
        d.rd_en   = 1'b0;
        d.sclk_prev = sclk_s;
        d.cs_prev   = cs_s;

        rise     = sclk_s & ~q.sclk_prev;
        fall     = ~sclk_s & q.sclk_prev;
        reserved = (q.addr > LAST_A);
        shifted  = {sdi_s, q.rx[DATA_W-1:1]};

        // deferred address step keeps reg_addr steady during the strobe
        if (q.adv) begin
            d.adv  = 1'b0;
            d.addr = (q.addr == LAST_A) ? '0 : q.addr + 1'b1;
        end

        if (!cs_s) begin
            d.phase = PH_IDLE;
            d.bcnt  = '0;
            d.drive = 1'b0;
        end else if (!q.cs_prev) begin
            d.phase = PH_CMD;
            d.bcnt  = '0;
            d.drive = 1'b0;
        end else begin
            if (rise && q.phase != PH_IDLE) begin
                d.rx = shifted;
                if (q.bcnt == BYTE_END) begin
                    d.bcnt = '0;
                    unique case (q.phase)
                        PH_CMD: begin
                            d.addr  = shifted[ADDR_W-1:0];
                            d.phase = shifted[DATA_W-1] ? PH_WR : PH_RD;
                        end
                        PH_WR: begin
                            d.wr_en = ~wp & ~reserved;
                            d.wdata = shifted;
                            d.adv   = 1'b1;
                        end
                        PH_RD: begin
                            d.adv = 1'b1;
                        end
                        default: ;
                    endcase
                end else begin
                    d.bcnt = q.bcnt + 1'b1;
                end
            end
            if (fall && q.phase == PH_RD) begin
                if (q.bcnt == '0) begin
                    d.tx    = reserved ? '0 : reg_rdata;
                    d.rd_en = ~reserved;
                    d.drive = 1'b1;
                end else begin
                    d.tx = q.tx >> 1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.phase <= PH_IDLE;
        end else begin
            q <= d;
        end
    end

    assign reg_addr  = q.addr;
    assign reg_wr_en = q.wr_en;
    assign reg_wdata = q.wdata;
    assign reg_rd_en = q.rd_en;
    assign sdo       = q.tx[0];
    assign drive     = q.drive;
    assign adc_hold  = (q.phase == PH_RD) && (q.addr == ADC_A);
endmodule

// File: rtl/tw_serial_regif.sv
module tw_serial_regif
    import tw_pkg::*;
#(
    parameter int LAST_ADDR   = 14,
    parameter int ADC_ADDR    = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs,
    input  logic              sclk,
    input  logic              sdio_in,
    output logic              sdio_out,
    output logic              sdio_oe,
    input  logic              wp,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              adc_hold
);
    localparam int NSIG = 3;

    logic [NSIG-1:0] raw, synced;
    logic            drive;

    assign raw = {cs, sclk, sdio_in};

    tw_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw),
        .dout  (synced)
    );

    tw_engine #(.LAST_ADDR(LAST_ADDR), .ADC_ADDR(ADC_ADDR)) eng_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_s      (synced[2]),
        .sclk_s    (synced[1]),
        .sdi_s     (synced[0]),
        .wp        (wp),
        .reg_rdata (reg_rdata),
        .reg_addr  (reg_addr),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .reg_rd_en (reg_rd_en),
        .sdo       (sdio_out),
        .drive     (drive),
        .adc_hold  (adc_hold)
    );

    // release the line as soon as select is low, ahead of the synchroniser
    assign sdio_oe = drive & cs;
endmodule

// File: rtl/tw_serial_regif_chk.sv
module tw_serial_regif_chk #(
    parameter int ADDR_W    = 7,
    parameter int LAST_ADDR = 14,
    parameter int ADC_ADDR  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs,
    input logic              wp,
    input logic              reg_wr_en,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              adc_hold
);
    assert_quiet_when_deselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs && !$past(cs, 1) && !$past(cs, 2) && !$past(cs, 3))
            |-> (!adc_hold && !reg_wr_en && !reg_rd_en));

    assert_strobes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    assert_no_reserved_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en || reg_rd_en) |-> (reg_addr <= ADDR_W'(LAST_ADDR)));

    assert_no_protected_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> !wp);

    assert_hold_on_result_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        adc_hold |-> (reg_addr == ADDR_W'(ADC_ADDR)));

    assert_single_write_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);
endmodule

bind tw_serial_regif tw_serial_regif_chk #(
    .ADDR_W    (tw_pkg::ADDR_W),
    .LAST_ADDR (LAST_ADDR),
    .ADC_ADDR  (ADC_ADDR)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs        (cs),
    .wp        (wp),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .adc_hold  (adc_hold)
);

// File: tb/tw_serial_regif_tb_top.sv
`timescale 1ns/1ps
module tw_serial_regif_tb_top;
    localparam int H     = 10;
    localparam int NREG  = 15;
    localparam int NVEC  = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, sclk = 1'b0, sdio_in = 1'b0, wp = 1'b0;
    logic       sdio_out, sdio_oe, reg_wr_en, reg_rd_en, adc_hold;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    logic [7:0] mem [NREG];
    int         wr_count;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    tw_serial_regif dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .wp(wp), .reg_addr(reg_addr),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rd_en(reg_rd_en),
        .reg_rdata(reg_rdata), .adc_hold(adc_hold)
    );

    // register file model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= 8'h10 + 8'(i);
            wr_count <= 0;
        end else if (reg_wr_en) begin
            wr_count <= wr_count + 1;
            if (int'(reg_addr) < NREG) mem[reg_addr] <= reg_wdata;
        end
    end
    assign reg_rdata = (int'(reg_addr) < NREG) ? mem[reg_addr[3:0]] : 8'hA5;

    // {write, addr[6:0], data[7:0]}
    localparam logic [15:0] VEC [NVEC] = '{
        {1'b1, 7'h01, 8'h37},
        {1'b1, 7'h05, 8'hC4},
        {1'b0, 7'h01, 8'h37},
        {1'b0, 7'h05, 8'hC4},
        {1'b1, 7'h20, 8'h99},
        {1'b0, 7'h20, 8'h00},
        {1'b0, 7'h7F, 8'h00},
        {1'b0, 7'h0E, 8'h1E}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start_xfer();
        sclk = 1'b0; cs = 1'b1; tick(H);
    endtask

    task automatic end_xfer();
        sclk = 1'b0; tick(H); cs = 1'b0; tick(H);
    endtask

    task automatic xbyte(input logic [7:0] din, output logic [7:0] dout);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; sdio_in = din[i]; tick(H);
            dout[i] = sdio_out;
            sclk = 1'b1; tick(H);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        logic [7:0] b0, b1, b2;
        int         wc;

        tick(4); rst_n = 1'b1; tick(2);
        // R10 reset state
        check("R10 oe", 32'(sdio_oe), 0);
        check("R10 wr", 32'(reg_wr_en), 0);
        check("R10 rd", 32'(reg_rd_en), 0);
        check("R10 hold", 32'(adc_hold), 0);
        check("R10 addr", 32'(reg_addr), 0);

        // vector table: R2 direction/address, R3 bit order, R6 reserved
        for (int v = 0; v < NVEC; v++) begin
            wc = wr_count;
            start_xfer();
            xbyte({VEC[v][15], VEC[v][14:8]}, got);
            xbyte(VEC[v][15] ? VEC[v][7:0] : 8'h00, got);
            end_xfer();
            if (VEC[v][15]) begin
                if (int'(VEC[v][14:8]) < NREG)
                    check("R2 R3 write value", 32'(mem[VEC[v][11:8]]), 32'(VEC[v][7:0]));
                else
                    check("R6 reserved write ignored", 32'(wr_count), 32'(wc));
            end else begin
                check("R3 R6 read value", 32'(got), 32'(VEC[v][7:0]));
            end
        end

        // R4: no drive during command, first bit after following falling edge
        start_xfer();
        xbyte(8'h05, got);
        check("R4 oe low through command", 32'(sdio_oe), 0);
        sclk = 1'b0; tick(H);
        check("R4 first bit driven", 32'(sdio_oe), 1);
        check("R4 first bit is bit0", 32'(sdio_out), 0);
        sclk = 1'b1; tick(H);
        end_xfer();
        check("R1 oe released", 32'(sdio_oe), 0);

        // R5: burst write wrapping 0Dh -> 0Eh -> 00h
        start_xfer();
        xbyte(8'h8D, got);
        xbyte(8'hA1, got); xbyte(8'hA2, got); xbyte(8'hA3, got);
        end_xfer();
        check("R5 burst 0Dh", 32'(mem[13]), 32'h A1);
        check("R5 burst 0Eh", 32'(mem[14]), 32'h A2);
        check("R5 burst wrap 00h", 32'(mem[0]), 32'h A3);

        // R5: burst read across the wrap
        start_xfer();
        xbyte(8'h0E, got);
        xbyte(8'h00, b0); xbyte(8'h00, b1);
        end_xfer();
        check("R5 burst read 0Eh", 32'(b0), 32'h A2);
        check("R5 burst read wrap", 32'(b1), 32'h A3);

        // R5: reserved burst 7Fh wraps to 00h
        start_xfer();
        xbyte(8'h7F, got);
        xbyte(8'h00, b0); xbyte(8'h00, b1);
        end_xfer();
        check("R6 read 7Fh zero", 32'(b0), 0);
        check("R5 7Fh wraps to 00h", 32'(b1), 32'h A3);

        // R7: write protect
        wp = 1'b1; wc = wr_count;
        start_xfer();
        xbyte(8'h83, got); xbyte(8'hEE, got);
        end_xfer();
        check("R7 protected write value", 32'(mem[3]), 32'h13);
        check("R7 protected write strobe", 32'(wr_count), 32'(wc));
        wp = 1'b0;

        // R9: truncated write byte discarded
        wc = wr_count;
        start_xfer();
        xbyte(8'h82, got);
        for (int i = 0; i < 5; i++) begin
            sclk = 1'b0; sdio_in = 1'b1; tick(H);
            sclk = 1'b1; tick(H);
        end
        cs = 1'b0; tick(H); sclk = 1'b0; tick(H);
        check("R9 partial byte value", 32'(mem[2]), 32'h12);
        check("R9 partial byte strobe", 32'(wr_count), 32'(wc));
        start_xfer();
        xbyte(8'h82, got); xbyte(8'h6B, got);
        end_xfer();
        check("R9 full byte after abort", 32'(mem[2]), 32'h6B);

        // R8: hold during read of 0Eh, released by deselect; R1 immediate release
        start_xfer();
        xbyte(8'h0E, got);
        check("R8 hold during read", 32'(adc_hold), 1);
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b0; tick(H);
            sclk = 1'b1; tick(H);
        end
        check("R8 hold mid byte", 32'(adc_hold), 1);
        cs = 1'b0; tick(1);
        check("R1 oe drops with select", 32'(sdio_oe), 0);
        tick(H);
        check("R8 hold released", 32'(adc_hold), 0);
        sclk = 1'b0; tick(H);

        // R8: hold drops once the 0Eh byte completes
        start_xfer();
        xbyte(8'h0E, got); xbyte(8'h00, b2);
        tick(H);
        check("R8 hold after byte", 32'(adc_hold), 0);
        end_xfer();
        check("R8 read value", 32'(b2), 32'h A2);

        finish_run();
    end
endmodule